// File: doc/BRIEF.md
# Integer ALU with Fault Flag

This block is the arithmetic-logic stage of a 32-bit integer datapath. It takes two operands and a 4-bit operation code from the ALU decoder. It returns a result word and one error bit. It covers addition, subtraction, the three bitwise logic operations, signed and unsigned set-less-than, and the three shifts. Address generation for loads and stores goes through the addition code: the base register is the first operand and the offset is the second.

The error bit is raised for two reasons. The first is an arithmetic wrap on add or subtract. That wrap is found by doing the operation one bit wider than the operands and reading the extra top bit. The second is an operation code that the unit does not implement. For such a code the unit gives a zero result and sets the error bit, so it never picks a default operation. Both outputs are registered: a result appears one clock after its inputs are presented. A synchronous active-high reset clears the outputs.

Top module: `alu_fault_top`

## Requirements
- R1: While `rst` is sampled high at a rising edge, `result_o` and `err_o` are 0 after that edge.
- R2: Outputs are registered. The values after rising edge N depend only on `op_i`, `a_i` and `b_i` sampled at edge N.
- R3: Code 2 (ADD) gives the low 32 bits of `a_i + b_i`. `err_o` is bit 32 of the 33-bit sum of the zero-extended operands.
- R4: Code 3 (SUB) gives the low 32 bits of `a_i - b_i`. `err_o` is bit 32 of the 33-bit difference of the zero-extended operands, so it is 1 exactly when `a_i < b_i` unsigned.
- R5: Code 0 gives AND, code 1 gives OR and code 4 gives XOR of the operands, with `err_o` = 0.
- R6: Code 5 (signed) and code 6 (unsigned) give 1 when `a_i < b_i` and 0 otherwise, with bits 31..1 zero and `err_o` = 0.
- R7: Code 7 shifts left logical, code 8 shifts right logical and code 9 shifts right arithmetic. Each shifts `a_i` by `b_i[4:0]`; bits 31..5 of `b_i` have no effect. `err_o` = 0.
- R8: Codes 10 to 15 give `result_o` = 0 and `err_o` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand (shift amount in bits 4..0) |
| result_o | output | 32 | Registered result |
| err_o | output | 1 | Registered overflow / illegal-code flag |

## Verification
The assertions assume that `op_i`, `a_i` and `b_i` are stable and known at every rising edge. They also assume that reset is held for at least one edge before the first operation is checked. The bench changes inputs only on falling edges and asserts reset from time zero, so each edge sees one settled operation. Stimulus covers every code in 0 to 15, including the six illegal ones. It drives wrap and no-wrap operand pairs for add and subtract, and shift amounts with stray upper bits in the second operand. Long random stretches with no restriction on code or operands follow the directed cases.

// File: rtl/alu_fault_pkg.sv
package alu_fault_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_AND  = 4'd0,
    OP_OR   = 4'd1,
    OP_ADD  = 4'd2,
    OP_SUB  = 4'd3,
    OP_XOR  = 4'd4,
    OP_SLT  = 4'd5,
    OP_SLTU = 4'd6,
    OP_SLL  = 4'd7,
    OP_SRL  = 4'd8,
    OP_SRA  = 4'd9
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'd0,
    SH_RIGHT = 2'd1,
    SH_ARITH = 2'd2
  } shift_kind_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sub,
  output logic [WIDTH-1:0] sum,
  output logic             top_bit
);
  localparam int XW = WIDTH + 1;
  logic [XW-1:0] wide;

  always_comb begin
    if (sub) wide = {1'b0, a} - {1'b0, b};
    else     wide = {1'b0, a} + {1'b0, b};
  end

  assign sum     = wide[WIDTH-1:0];
  assign top_bit = wide[XW-1];
endmodule

// File: rtl/alu_shift.sv
module alu_shift
  import alu_fault_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int SHW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] a,
  input  logic [SHW-1:0]   amt,
  input  shift_kind_e      kind,
  output logic [WIDTH-1:0] y
);
  always_comb begin
    unique case (kind)
      SH_LEFT:  y = a << amt;
      SH_RIGHT: y = a >> amt;
      SH_ARITH: y = WIDTH'($signed(a) >>> amt);
      default:  y = '0;
    endcase
  end
endmodule

// File: rtl/alu_logic_cmp.sv
module alu_logic_cmp #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] and_y,
  output logic [WIDTH-1:0] or_y,
  output logic [WIDTH-1:0] xor_y,
  output logic             lt_s,
  output logic             lt_u
);
  assign and_y = a & b;
  assign or_y  = a | b;
  assign xor_y = a ^ b;
  assign lt_s  = $signed(a) < $signed(b);
  assign lt_u  = a < b;
endmodule

// File: rtl/alu_fault_top.sv
module alu_fault_top
  import alu_fault_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int SHW = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OP_W-1:0]  op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] result_o,
  output logic             err_o
);
  logic [WIDTH-1:0] as_sum, sh_y, and_y, or_y, xor_y;
  logic             as_top, lt_s, lt_u, is_sub;
  shift_kind_e      sh_kind;
  logic [WIDTH-1:0] nxt_res;
  logic             nxt_err;

  assign is_sub = (op_i == OP_SUB);

  always_comb begin
    unique case (op_i)
      OP_SRL:  sh_kind = SH_RIGHT;
      OP_SRA:  sh_kind = SH_ARITH;
      default: sh_kind = SH_LEFT;
    endcase
  end

  alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a(a_i), .b(b_i), .sub(is_sub), .sum(as_sum), .top_bit(as_top)
  );

  alu_shift #(.WIDTH(WIDTH)) u_shift (
    .a(a_i), .amt(b_i[SHW-1:0]), .kind(sh_kind), .y(sh_y)
  );

  alu_logic_cmp #(.WIDTH(WIDTH)) u_lc (
    .a(a_i), .b(b_i), .and_y(and_y), .or_y(or_y), .xor_y(xor_y),
    .lt_s(lt_s), .lt_u(lt_u)
  );

  always_comb begin
    nxt_res = '0;
    nxt_err = 1'b0;
    case (op_i)
      OP_AND:  nxt_res = and_y;
      OP_OR:   nxt_res = or_y;
      OP_XOR:  nxt_res = xor_y;
      OP_ADD, OP_SUB: begin
        nxt_res = as_sum;
        nxt_err = as_top;
      end
      OP_SLT:  nxt_res = {{(WIDTH-1){1'b0}}, lt_s};
      OP_SLTU: nxt_res = {{(WIDTH-1){1'b0}}, lt_u};
      OP_SLL, OP_SRL, OP_SRA: nxt_res = sh_y;
      default: begin
        nxt_res = '0;
        nxt_err = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      err_o    <= 1'b0;
    end else begin
      result_o <= nxt_res;
      err_o    <= nxt_err;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (result_o == '0 && !err_o));

  // R8
  illegal_code_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i > OP_SRA) |=> (err_o && result_o == '0));

  // R5
  logic_no_err_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR) |=> !err_o);

  // R6
  slt_bool_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_SLT || op_i == OP_SLTU) |=> (result_o[WIDTH-1:1] == '0 && !err_o));

  // R7
  shift_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ((op_i == OP_SLL || op_i == OP_SRL || op_i == OP_SRA) && b_i[SHW-1:0] == '0)
      |=> (result_o == $past(a_i) && !err_o));

  // R4
  sub_equal_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_SUB && a_i == b_i) |=> (result_o == '0 && !err_o));
endmodule

// File: tb/alu_fault_top_tb.sv
module alu_fault_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op_i = '0;
  logic [31:0] a_i = '0, b_i = '0;
  logic [31:0] result_o;
  logic        err_o;

  int checks = 0, errors = 0;
  logic        have_exp = 1'b0;
  logic [31:0] exp_res;
  logic        exp_err;
  string       exp_tag;

  always #2 clk = ~clk;

  alu_fault_top u_dut (
    .clk(clk), .rst(rst), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .result_o(result_o), .err_o(err_o)
  );

  function automatic string tag_of(input logic r, input logic [3:0] op);
    if (r) return "R1";
    case (op)
      4'd0, 4'd1, 4'd4: return "R5";
      4'd2: return "R3";
      4'd3: return "R4";
      4'd5, 4'd6: return "R6";
      4'd7, 4'd8, 4'd9: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic model(input logic r, input logic [3:0] op,
                       input logic [31:0] a, input logic [31:0] b,
                       output logic [31:0] res, output logic err);
    logic [32:0] w;
    int sa;
    sa = int'(b % 32);
    res = 0; err = 0;
    if (r) return;
    case (op)
      0: res = a & b;
      1: res = a | b;
      4: res = a ^ b;
      2: begin w = {1'b0, a} + {1'b0, b}; res = w[31:0]; err = w[32]; end
      3: begin w = {1'b0, a} - {1'b0, b}; res = w[31:0]; err = w[32]; end
      5: res = ($signed(a) < $signed(b)) ? 1 : 0;
      6: res = (a < b) ? 1 : 0;
      7: for (int i = 0; i < 32; i++) res[i] = (i >= sa) ? a[i-sa] : 1'b0;
      8: for (int i = 0; i < 32; i++) res[i] = (i + sa < 32) ? a[i+sa] : 1'b0;
      9: for (int i = 0; i < 32; i++) res[i] = (i + sa < 32) ? a[i+sa] : a[31];
      default: begin res = 0; err = 1; end
    endcase
  endtask

  // R2: each check compares the outputs one edge after the inputs were applied
  task automatic step(input logic r, input logic [3:0] op,
                      input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    if (have_exp) begin
      checks++;
      if (result_o !== exp_res || err_o !== exp_err) begin
        errors++;
        $display("FAIL %s (R2 timing): result=%h err=%b expected result=%h err=%b",
                 exp_tag, result_o, err_o, exp_res, exp_err);
      end
    end
    rst = r; op_i = op; a_i = a; b_i = b;
    model(r, op, a, b, exp_res, exp_err);
    exp_tag = tag_of(r, op);
    have_exp = 1'b1;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(1, 4'd2, 32'hFFFF_FFFF, 32'h1);   // R1 reset
    step(1, 4'd15, 0, 0);                  // R1
    step(0, 4'd2, 32'd2, 32'd3);           // R3
    step(0, 4'd2, 32'hFFFF_FFFF, 32'd1);   // R3 carry out
    step(0, 4'd2, 32'h7FFF_FFFF, 32'd1);   // R3 no top bit
    step(0, 4'd3, 32'd7, 32'd5);           // R4
    step(0, 4'd3, 32'd5, 32'd7);           // R4 borrow
    step(0, 4'd3, 32'h1234, 32'h1234);     // R4 equal
    step(0, 4'd0, 32'hF0F0_00FF, 32'h0FF0_0F0F); // R5
    step(0, 4'd1, 32'hF0F0_00FF, 32'h0FF0_0F0F); // R5
    step(0, 4'd4, 32'hF0F0_00FF, 32'h0FF0_0F0F); // R5
    step(0, 4'd5, 32'hFFFF_FFFF, 32'd1);   // R6 signed: -1<1
    step(0, 4'd6, 32'hFFFF_FFFF, 32'd1);   // R6 unsigned: no
    step(0, 4'd5, 32'd1, 32'd1);           // R6 equal
    step(0, 4'd7, 32'h8000_0001, 32'hFFFF_FFE5); // R7 upper b bits ignored
    step(0, 4'd8, 32'h8000_0001, 32'h0000_0125); // R7
    step(0, 4'd9, 32'h8000_0000, 32'hABCD_EF1F); // R7 arith by 31
    step(0, 4'd9, 32'h4000_0000, 32'd0);   // R7 zero shift
    for (int c = 10; c < 16; c++) step(0, 4'(c), 32'hDEAD_BEEF, 32'h1); // R8
    step(1, 4'd2, 32'hFFFF_FFFF, 32'h1);   // R1 mid-stream reset
    for (int n = 0; n < 3000; n++)
      step(0, 4'($urandom_range(0, 15)), $urandom, $urandom);
    step(0, 4'd0, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule